// File: doc/BRIEF.md
# Recursive Single-Bin DFT Accumulator

This block computes one frequency bin of an N-point discrete Fourier transform from a stream of complex samples. It does not sum the products against a table of twiddle factors. It folds each accepted sample into one complex state register using nested (Horner) evaluation. Each accepted sample is added to the state, and the sum is multiplied by a fixed complex coefficient. The earliest sample of the frame therefore ends up in the innermost term. With the coefficient set to e^{+j2πk/N}, the state after N samples equals X[k] = Σ x[n]·e^{-j2πnk/N}.

A wrapping sample counter marks the end of each frame. On the N-th accepted sample, the folded value goes to a result register, a one-cycle valid pulse is raised, and the state is cleared for the next frame. A synchronous frame restart input drops a partial frame. The datapath uses one feedback register per component and four real multipliers. Each product is rescaled by 17 fractional bits with round-half-up, and each component saturates at the accumulator width. N must be a power of two and at least 2.

Top module: `dft_bin_horner`

## Requirements
- R1: While reset is asserted and in the first cycle after it, result_valid is 0, result_re and result_im are 0, and the internal state is zero.
- R2: On each cycle with sample_valid high, the state becomes (s + x)·c. Here s is the state, or zero when frame_restart is also high, and c is coef_re + j·coef_im, an 18-bit signed value with 17 fractional bits. The real part is ar·cr − ai·ci and the imaginary part is ar·ci + ai·cr. Each part is rounded as floor((p + 2^16) / 2^17).
- R3: After rounding, each component of the new state is clamped to the signed ACC_W-bit range [−2^(ACC_W−1), 2^(ACC_W−1)−1]. It does not wrap.
- R4: On the N-th accepted sample of a frame, result_re/result_im take the folded value and are visible after that clock edge. result_valid is high for exactly that one cycle. The result holds its value until the next pulse.
- R5: The sample accepted right after a result pulse starts a new frame from a zero state. Back-to-back frames need no idle cycle.
- R6: A cycle with sample_valid low and frame_restart low changes neither the state nor the sample count, whatever the sample inputs carry.
- R7: frame_restart high discards the partial frame. If sample_valid is high in the same cycle, that sample is the first of the new frame.
- R8: With c = e^{+j2πk/N} quantised to 18 bits, each result component is within 32 LSB of the exact DFT bin k of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_restart | input | 1 | Discard partial frame; a same-cycle sample starts the new frame |
| sample_valid | input | 1 | Sample qualifier |
| sample_re | input | DATA_W | Sample real part, signed |
| sample_im | input | DATA_W | Sample imaginary part, signed |
| coef_re | input | 18 | Coefficient real part, signed, 17 fractional bits |
| coef_im | input | 18 | Coefficient imaginary part, signed, 17 fractional bits |
| result_valid | output | 1 | One-cycle pulse when a bin result is ready |
| result_re | output | ACC_W | Bin result real part, signed |
| result_im | output | ACC_W | Bin result imaginary part, signed |

## Verification
The fold is driven with several frame patterns:
- An impulse at the first sample, which isolates the full chain of N coefficient multiplies.
- A constant frame, which separates a bin that builds up from one that cancels.
- An alternating-sign frame, which targets the Nyquist bin.
- A ramp, which weights each position differently and so exposes wrong ordering.

Every pattern is compared bit-exactly against a rounding and saturation model. The same frames are also compared within a tolerance against a floating-point transform, which catches a wrong coefficient sense or wrong frame alignment. A coefficient of magnitude √2 with full-scale inputs forces clamping. Idle gaps with junk data, mid-frame restarts and back-to-back frames check the counter and state clearing.

// File: rtl/dft_bin_pkg.sv
package dft_bin_pkg;
    localparam int COEF_W    = 18;
    localparam int COEF_FRAC = 17;

    typedef logic signed [COEF_W-1:0] coef_t;
endpackage

// File: rtl/dft_round_sat.sv
module dft_round_sat #(
    parameter int IN_W  = 44,
    parameter int OUT_W = 20,
    parameter int SHIFT = 17
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] res_o
);
    localparam int EXT_W = IN_W + 1;
    localparam logic signed [EXT_W-1:0] HALF = EXT_W'(64'd1 << (SHIFT - 1));
    localparam logic signed [EXT_W-1:0] MAXV = EXT_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [EXT_W-1:0] MINV = -MAXV - EXT_W'(1);

    logic signed [EXT_W-1:0] biased_d;
    logic signed [EXT_W-1:0] shifted_d;

    always_comb begin
        biased_d  = $signed({val_i[IN_W-1], val_i}) + HALF;
        shifted_d = biased_d >>> SHIFT;
        if (shifted_d > MAXV) begin
            res_o = MAXV[OUT_W-1:0];
        end else if (shifted_d < MINV) begin
            res_o = MINV[OUT_W-1:0];
        end else begin
            res_o = shifted_d[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/dft_cplx_step.sv
module dft_cplx_step
    import dft_bin_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic signed [ACC_W-1:0]  base_re_i,
    input  logic signed [ACC_W-1:0]  base_im_i,
    input  logic signed [DATA_W-1:0] x_re_i,
    input  logic signed [DATA_W-1:0] x_im_i,
    input  coef_t                    c_re_i,
    input  coef_t                    c_im_i,
    output logic signed [ACC_W-1:0]  nxt_re_o,
    output logic signed [ACC_W-1:0]  nxt_im_o
);
    localparam int SUM_W   = ACC_W + 1;
    localparam int PROD_W  = SUM_W + COEF_W;
    localparam int CROSS_W = PROD_W + 1;

    logic signed [SUM_W-1:0]   sum_re_d, sum_im_d;
    logic signed [PROD_W-1:0]  p_rr_d, p_ii_d, p_ri_d, p_ir_d;
    logic signed [CROSS_W-1:0] cross_d [2];
    logic signed [ACC_W-1:0]   rs_out  [2];

    function automatic logic signed [PROD_W-1:0] mul_sc(
        input logic signed [SUM_W-1:0] a,
        input coef_t                   b
    );
        logic signed [PROD_W-1:0] ax, bx;
        ax = $signed({{COEF_W{a[SUM_W-1]}}, a});
        bx = $signed({{SUM_W{b[COEF_W-1]}}, b});
        return ax * bx;
    endfunction

    always_comb begin
        sum_re_d = $signed({base_re_i[ACC_W-1], base_re_i})
                 + $signed({{(SUM_W-DATA_W){x_re_i[DATA_W-1]}}, x_re_i});
        sum_im_d = $signed({base_im_i[ACC_W-1], base_im_i})
                 + $signed({{(SUM_W-DATA_W){x_im_i[DATA_W-1]}}, x_im_i});
        p_rr_d = mul_sc(sum_re_d, c_re_i);
        p_ii_d = mul_sc(sum_im_d, c_im_i);
        p_ri_d = mul_sc(sum_re_d, c_im_i);
        p_ir_d = mul_sc(sum_im_d, c_re_i);
        cross_d[0] = $signed({p_rr_d[PROD_W-1], p_rr_d}) - $signed({p_ii_d[PROD_W-1], p_ii_d});
        cross_d[1] = $signed({p_ri_d[PROD_W-1], p_ri_d}) + $signed({p_ir_d[PROD_W-1], p_ir_d});
    end

    for (genvar g = 0; g < 2; g++) begin : g_part
        dft_round_sat #(
            .IN_W (CROSS_W),
            .OUT_W(ACC_W),
            .SHIFT(COEF_FRAC)
        ) u_rs (
            .val_i(cross_d[g]),
            .res_o(rs_out[g])
        );
    end

    assign nxt_re_o = rs_out[0];
    assign nxt_im_o = rs_out[1];
endmodule

// File: rtl/dft_frame_counter.sv
module dft_frame_counter #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic advance_i,
    output logic frame_end_o
);
    localparam int CNT_W = (N > 2) ? $clog2(N) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t        cur_q, cur_d;
    logic [CNT_W-1:0] base_d;

    always_comb begin
        cur_d       = cur_q;
        frame_end_o = 1'b0;
        base_d      = restart_i ? '0 : cur_q.cnt;
        if (advance_i) begin
            frame_end_o = (base_d == CNT_W'(N - 1));
            cur_d.cnt   = base_d + CNT_W'(1);
        end else if (restart_i) begin
            cur_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    // R6: without a sample or restart the position in the frame is frozen
    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !restart_i) |=> $stable(cur_q.cnt));

    // R7: a bare restart leaves the counter at the frame start
    p_count_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !advance_i) |=> (cur_q.cnt == '0));
endmodule

// File: rtl/dft_bin_horner.sv
module dft_bin_horner
    import dft_bin_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_restart,
    input  logic                     sample_valid,
    input  logic signed [DATA_W-1:0] sample_re,
    input  logic signed [DATA_W-1:0] sample_im,
    input  logic signed [17:0]       coef_re,
    input  logic signed [17:0]       coef_im,
    output logic                     result_valid,
    output logic signed [ACC_W-1:0]  result_re,
    output logic signed [ACC_W-1:0]  result_im
);
    typedef struct packed {
        logic signed [ACC_W-1:0] st_re;
        logic signed [ACC_W-1:0] st_im;
        logic signed [ACC_W-1:0] out_re;
        logic signed [ACC_W-1:0] out_im;
        logic                    out_vld;
    } bin_regs_t;

    bin_regs_t               regs_q, regs_d;
    logic signed [ACC_W-1:0] base_re_d, base_im_d;
    logic signed [ACC_W-1:0] step_re_d, step_im_d;
    logic                    frame_end_d;

    dft_frame_counter #(.N(N)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (frame_restart),
        .advance_i  (sample_valid),
        .frame_end_o(frame_end_d)
    );

    dft_cplx_step #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_step (
        .base_re_i(base_re_d),
        .base_im_i(base_im_d),
        .x_re_i   (sample_re),
        .x_im_i   (sample_im),
        .c_re_i   (coef_re),
        .c_im_i   (coef_im),
        .nxt_re_o (step_re_d),
        .nxt_im_o (step_im_d)
    );

    always_comb begin
        regs_d         = regs_q;
        regs_d.out_vld = 1'b0;
        base_re_d      = frame_restart ? '0 : regs_q.st_re;
        base_im_d      = frame_restart ? '0 : regs_q.st_im;
        if (sample_valid) begin
            if (frame_end_d) begin
                regs_d.out_re  = step_re_d;
                regs_d.out_im  = step_im_d;
                regs_d.out_vld = 1'b1;
                regs_d.st_re   = '0;
                regs_d.st_im   = '0;
            end else begin
                regs_d.st_re = step_re_d;
                regs_d.st_im = step_im_d;
            end
        end else if (frame_restart) begin
            regs_d.st_re = '0;
            regs_d.st_im = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign result_valid = regs_q.out_vld;
    assign result_re    = regs_q.out_re;
    assign result_im    = regs_q.out_im;

    // R4: the ready flag never lasts more than one cycle
    p_pulse_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    // R4: between pulses the published bin does not move
    p_result_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> ($stable(result_re) && $stable(result_im)));

    // R5: a finished frame leaves the fold empty
    p_state_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (regs_q.st_re == '0 && regs_q.st_im == '0));

    // R6: idle cycles touch nothing
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_valid && !frame_restart) |=>
            ($stable(regs_q.st_re) && $stable(regs_q.st_im) && !result_valid));

    // R7: a bare restart empties the fold and raises no result
    p_restart_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_restart && !sample_valid) |=>
            (regs_q.st_re == '0 && regs_q.st_im == '0 && !result_valid));
endmodule

// File: tb/dft_bin_horner_bench.sv
module dft_bin_horner_bench;
    localparam int N      = 8;
    localparam int DATA_W = 16;
    localparam int ACC_W  = 20;
    localparam longint AMAX = (64'sd1 <<< (ACC_W - 1)) - 1;
    localparam int TOL    = 32;
    localparam int NV     = 9;
    // stimulus table: {bin k (-1 = coefficient 1+j), pattern, amplitude}
    localparam int VEC [NV][3] = '{
        '{0, 0, 1000}, '{1, 0, 1000}, '{0, 1, 2000}, '{2, 1, 2000},
        '{4, 2, 3000}, '{1, 3, 4000}, '{3, 2, 5000}, '{5, 3, 32767},
        '{-1, 4, 32767}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_restart = 1'b0;
    logic sample_valid = 1'b0;
    logic signed [DATA_W-1:0] sample_re = '0, sample_im = '0;
    logic signed [17:0] coef_re = '0, coef_im = '0;
    logic result_valid;
    logic signed [ACC_W-1:0] result_re, result_im;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    longint msr, msi, cr_m, ci_m;
    longint smp_re [N];
    longint smp_im [N];

    always #4 clk = ~clk;

    dft_bin_horner #(.N(N), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_dft_bin_horner (
        .clk(clk), .rst_n(rst_n), .frame_restart(frame_restart),
        .sample_valid(sample_valid), .sample_re(sample_re), .sample_im(sample_im),
        .coef_re(coef_re), .coef_im(coef_im), .result_valid(result_valid),
        .result_re(result_re), .result_im(result_im)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input longint act, input real exp);
        real d;
        checks++;
        d = real'(act) - exp;
        if (d < 0.0) d = -d;
        if (d > real'(TOL)) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%f", req, act, exp);
        end
    endtask

    function automatic longint rnd_sat(input longint v);
        longint r;
        r = (v + 64'sd65536) >>> 17;
        if (r > AMAX) r = AMAX;
        else if (r < -AMAX - 1) r = -AMAX - 1;
        return r;
    endfunction

    task automatic mstep(input longint xr, input longint xi);
        longint ar, ai;
        ar = msr + xr;
        ai = msi + xi;
        msr = rnd_sat(ar * cr_m - ai * ci_m);
        msi = rnd_sat(ar * ci_m + ai * cr_m);
    endtask

    function automatic longint qcoef(input int k, input bit want_im);
        real ang, v;
        longint q;
        if (k < 0) return 131071;
        ang = 2.0 * 3.14159265358979 * real'(k) / real'(N);
        v = want_im ? $sin(ang) : $cos(ang);
        q = longint'($floor(v * 131072.0 + 0.5));
        if (q > 131071) q = 131071;
        if (q < -131072) q = -131072;
        return q;
    endfunction

    task automatic make_frame(input int pat, input int amp);
        for (int n = 0; n < N; n++) begin
            case (pat)
                0: begin smp_re[n] = (n == 0) ? amp : 0; smp_im[n] = 0; end
                1: begin smp_re[n] = amp; smp_im[n] = -(amp / 2); end
                2: begin smp_re[n] = (n % 2 == 1) ? -amp : amp; smp_im[n] = amp / 3; end
                3: begin smp_re[n] = (amp * n) / N - amp / 2; smp_im[n] = (amp * (N - n)) / N; end
                default: begin smp_re[n] = amp; smp_im[n] = amp; end
            endcase
        end
    endtask

    task automatic set_coef(input int k);
        cr_m = qcoef(k, 1'b0);
        ci_m = qcoef(k, 1'b1);
        coef_re = 18'(cr_m);
        coef_im = 18'(ci_m);
    endtask

    task automatic drive(input bit v, input bit rs, input longint xr, input longint xi);
        @(negedge clk);
        sample_valid = v;
        frame_restart = rs;
        sample_re = DATA_W'(xr);
        sample_im = DATA_W'(xi);
    endtask

    task automatic feed_frame;
        msr = 0;
        msi = 0;
        for (int n = 0; n < N; n++) begin
            drive(1'b1, 1'b0, smp_re[n], smp_im[n]);
            mstep(smp_re[n], smp_im[n]);
        end
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid in reset", longint'(result_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", longint'(result_valid), 0);
        check("R1 result_re after reset", longint'(result_re), 0);
        check("R1 result_im after reset", longint'(result_im), 0);

        // table walk: bit-exact fold (R2, R3) and transform accuracy (R8)
        for (int v = 0; v < NV; v++) begin
            real er, ei, ang;
            set_coef(VEC[v][0]);
            make_frame(VEC[v][1], VEC[v][2]);
            feed_frame();
            drive(1'b0, 1'b0, 0, 0);
            check("R4 pulse on N-th sample", longint'(result_valid), 1);
            check("R2 fold real", longint'(result_re), msr);
            check("R2 fold imag", longint'(result_im), msi);
            if (VEC[v][0] >= 0) begin
                er = 0.0;
                ei = 0.0;
                for (int n = 0; n < N; n++) begin
                    ang = -2.0 * 3.14159265358979 * real'(VEC[v][0] * n) / real'(N);
                    er += real'(smp_re[n]) * $cos(ang) - real'(smp_im[n]) * $sin(ang);
                    ei += real'(smp_re[n]) * $sin(ang) + real'(smp_im[n]) * $cos(ang);
                end
                check_near("R8 bin real", longint'(result_re), er);
                check_near("R8 bin imag", longint'(result_im), ei);
            end else begin
                check("R3 clamp to positive limit", longint'(result_re), AMAX);
            end
            drive(1'b0, 1'b0, 0, 0);
            check("R4 pulse is one cycle", longint'(result_valid), 0);
        end

        // R4: result holds through idle cycles after the pulse
        begin
            longint hr, hi;
            hr = longint'(result_re);
            hi = longint'(result_im);
            repeat (4) drive(1'b0, 1'b0, 0, 0);
            check("R4 hold real", longint'(result_re), hr);
            check("R4 hold imag", longint'(result_im), hi);
        end

        // R6: idle gaps with junk data between samples
        set_coef(1);
        make_frame(3, 3000);
        msr = 0;
        msi = 0;
        for (int n = 0; n < N; n++) begin
            drive(1'b1, 1'b0, smp_re[n], smp_im[n]);
            mstep(smp_re[n], smp_im[n]);
            drive(1'b0, 1'b0, 12345, -23456);
            drive(1'b0, 1'b0, -32768, 32767);
            if (n < N - 1) check("R6 no pulse during gaps", longint'(result_valid), 0);
        end
        check("R6 gapped frame pulse", longint'(result_valid), 0);
        check("R6 gapped frame real", longint'(result_re), msr);
        check("R6 gapped frame imag", longint'(result_im), msi);

        // R5: two frames back to back, the second from a zero state
        set_coef(2);
        make_frame(2, 4000);
        feed_frame();
        begin
            longint ar, ai;
            ar = msr;
            ai = msi;
            make_frame(1, 1500);
            msr = 0;
            msi = 0;
            drive(1'b1, 1'b0, smp_re[0], smp_im[0]);
            check("R5 first frame pulse", longint'(result_valid), 1);
            check("R5 first frame real", longint'(result_re), ar);
            check("R5 first frame imag", longint'(result_im), ai);
            mstep(smp_re[0], smp_im[0]);
            for (int n = 1; n < N; n++) begin
                drive(1'b1, 1'b0, smp_re[n], smp_im[n]);
                mstep(smp_re[n], smp_im[n]);
            end
            drive(1'b0, 1'b0, 0, 0);
            check("R5 second frame pulse", longint'(result_valid), 1);
            check("R5 second frame real", longint'(result_re), msr);
            check("R5 second frame imag", longint'(result_im), msi);
        end

        // R7: restart with a sample mid-frame; that sample is the first of the new frame
        set_coef(3);
        make_frame(0, 777);
        for (int n = 0; n < 3; n++) drive(1'b1, 1'b0, 9000, -9000);
        make_frame(3, 6000);
        msr = 0;
        msi = 0;
        drive(1'b1, 1'b1, smp_re[0], smp_im[0]);
        mstep(smp_re[0], smp_im[0]);
        for (int n = 1; n < N; n++) begin
            drive(1'b1, 1'b0, smp_re[n], smp_im[n]);
            mstep(smp_re[n], smp_im[n]);
            if (n == N - 3) check("R7 no early pulse", longint'(result_valid), 0);
        end
        drive(1'b0, 1'b0, 0, 0);
        check("R7 restart with sample pulse", longint'(result_valid), 1);
        check("R7 restart with sample real", longint'(result_re), msr);
        check("R7 restart with sample imag", longint'(result_im), msi);

        // R7: bare restart drops a partial frame
        for (int n = 0; n < 5; n++) drive(1'b1, 1'b0, -4000, 2500);
        drive(1'b0, 1'b1, 0, 0);
        set_coef(1);
        make_frame(1, 2500);
        feed_frame();
        drive(1'b0, 1'b0, 0, 0);
        check("R7 bare restart pulse", longint'(result_valid), 1);
        check("R7 bare restart real", longint'(result_re), msr);
        check("R7 bare restart imag", longint'(result_im), msi);

        drive(1'b0, 1'b0, 0, 0);
        finish_run();
    end
endmodule